// File: doc/BRIEF.md
# Power-Domain Wake-and-Access Register Proxy

This block is a slave on a host register bus that gives the host a way to reach a register inside a power-gated domain without first keeping that domain awake. The host sees two 32-bit registers: a data word and a command word. Setting the go bit in a command write makes the block do four things in order. It raises wake requests for the domains coded in the command and waits for their acknowledges. It performs one 32-bit read or write on a downstream single-beat register bus. For a read, it stores the returned word in the data register. It then drops the wake requests and clears the go bit.

A write is issued by loading the data register and then writing the command. A read is issued with a command alone; the host polls the go bit until it reads zero, then reads the data register. A 64-bit quantity takes two commands, one at the offset and one at the offset plus 4. Acknowledges from the power controller pass through a parameterised synchroniser before the sequencer acts on them. The go bit stays set until the released domains have dropped their acknowledges, so every wake handshake completes all four phases before the next one starts.

Top module: `pgate_reg_proxy`

## Requirements
- R1: After reset the command readback is 0, the data register is 0, no wake request is raised and no downstream request is raised.
- R2: The data register is at host offset 0xF00 and the command register at 0xF04. Command readback puts the go/busy flag at bit 31, the domain code at bits 29:28, the operation at bit 24 and the target offset at bits 23:0. Bits 30 and 27:25 read 0 even when written 1, and any other host offset reads 0.
- R3: A command write with bit 31 set while the block is idle starts one access, and bit 31 reads 1 from the next cycle. A command write with bit 31 clear starts nothing.
- R4: Wake request bit 0 is the blitter domain, bit 1 the render domain and bit 2 the media domain. Domain code 0, 1 or 2 raises only that bit. Code 3 raises all three bits. Requests are raised in the cycle after the command is accepted.
- R5: The downstream request is raised only after every requested domain shows a synchronised acknowledge. It stays raised, with address, direction and write data unchanged, until the target acknowledges.
- R6: Operation code 0 is a write. The downstream bus carries direction 1, address equal to the command offset, and write data equal to the data register.
- R7: Operation code 1 is a read. The word returned with the target acknowledge is stored in the data register and reads back from the next cycle.
- R8: In the cycle after the target acknowledge, the wake requests and the downstream request are low. Bit 31 clears in the first cycle after the synchronised acknowledges of the requested domains have all fallen.
- R9: While bit 31 is set, writes to the command register and to the data register are ignored.
- R10: Each command moves exactly one 32-bit word. Two commands at offsets N and N+4 return the two halves of a 64-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_en | input | 1 | Host access strobe, one cycle per access |
| hst_we | input | 1 | Host access is a write |
| hst_addr | input | HADDR_W (12) | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational from hst_addr |
| wake_req | output | 3 | Wake request per domain (bit 0 blitter, 1 render, 2 media) |
| wake_ack | input | 3 | Wake acknowledge per domain from the power controller |
| dn_req | output | 1 | Downstream access request, held until dn_ack |
| dn_we | output | 1 | Downstream direction, 1 for write |
| dn_addr | output | OFFS_W (24) | Downstream target offset |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |
| dn_ack | input | 1 | Downstream completion, one cycle |

## Verification
Bit 31 and the wake requests change at the edge that accepts the command. The downstream request rises one edge after the acknowledges have passed the two-stage synchroniser, so three edges after the power controller raises them. Read data and the dropped wake and downstream requests appear at the edge after the target acknowledge. Bit 31 clears three edges after the last acknowledge falls. A behavioural model in the bench steps through these same delays from the bench-driven inputs alone. Every clock, 2 ns after the edge, it is compared with the host readback and all downstream and wake outputs. Scenario checks then confirm the stored values, the wake masks and the number of downstream beats at the ports.

// File: rtl/pgate_proxy_pkg.sv
package pgate_proxy_pkg;
   localparam int unsigned NUM_DOM     = 3;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned CMD_GO_BIT  = 31;
   localparam int unsigned CMD_DOM_LSB = 28;
   localparam int unsigned CMD_OP_BIT  = 24;

   typedef enum logic [1:0] {
      DOM_BLIT  = 2'd0,
      DOM_REND  = 2'd1,
      DOM_MEDIA = 2'd2,
      DOM_ALL   = 2'd3
   } dom_code_e;

   typedef enum logic {
      OP_WR = 1'b0,
      OP_RD = 1'b1
   } op_code_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_WAKE = 2'd1,
      SQ_XFER = 2'd2,
      SQ_REL  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/pgate_win_regs.sv
module pgate_win_regs
   import pgate_proxy_pkg::*;
#(
   parameter int unsigned HADDR_W  = 12,
   parameter int unsigned OFFS_W   = 24,
   parameter int unsigned DATA_OFF = 'hF00,
   parameter int unsigned CMD_OFF  = 'hF04
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hst_en,
   input  logic               hst_we,
   input  logic [HADDR_W-1:0] hst_addr,
   input  logic [WORD_W-1:0]  hst_wdata,
   output logic [WORD_W-1:0]  hst_rdata,
   input  logic               seq_busy,
   input  logic               rd_cap,
   input  logic [WORD_W-1:0]  rd_word,
   output logic               start,
   output dom_code_e          cmd_dom,
   output op_code_e           cmd_op,
   output logic [OFFS_W-1:0]  cmd_offs,
   output logic [WORD_W-1:0]  data_word
);
   localparam logic [HADDR_W-1:0] DATA_A = HADDR_W'(DATA_OFF);
   localparam logic [HADDR_W-1:0] CMD_A  = HADDR_W'(CMD_OFF);

   logic              sel_data, sel_cmd, wr_data;
   logic [WORD_W-1:0] cmd_view;

   assign sel_data = (hst_addr == DATA_A);
   assign sel_cmd  = (hst_addr == CMD_A);
   assign start    = hst_en && hst_we && sel_cmd && hst_wdata[CMD_GO_BIT] && !seq_busy;
   assign wr_data  = hst_en && hst_we && sel_data && !seq_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_dom  <= DOM_BLIT;
         cmd_op   <= OP_WR;
         cmd_offs <= '0;
      end else if (start) begin
         cmd_dom  <= dom_code_e'(hst_wdata[CMD_DOM_LSB +: 2]);
         cmd_op   <= op_code_e'(hst_wdata[CMD_OP_BIT]);
         cmd_offs <= hst_wdata[OFFS_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_word <= '0;
      else if (rd_cap)  data_word <= rd_word;
      else if (wr_data) data_word <= hst_wdata;
   end

   always_comb begin
      cmd_view                       = '0;
      cmd_view[CMD_GO_BIT]           = seq_busy;
      cmd_view[CMD_DOM_LSB +: 2]     = cmd_dom;
      cmd_view[CMD_OP_BIT]           = cmd_op;
      cmd_view[OFFS_W-1:0]           = cmd_offs;
   end

   always_comb begin
      if (sel_data)     hst_rdata = data_word;
      else if (sel_cmd) hst_rdata = cmd_view;
      else              hst_rdata = '0;
   end

   // R9: command fields frozen while an access is pending
   p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_busy |=> ($stable(cmd_offs) && $stable(cmd_op) && $stable(cmd_dom)))
      else $error("command changed while busy");

   // R9: data word only changes by capture while busy
   p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && !rd_cap) |=> $stable(data_word))
      else $error("data word changed while busy");
endmodule

// File: rtl/pgate_dom_decode.sv
module pgate_dom_decode
   import pgate_proxy_pkg::*;
(
   input  dom_code_e          code,
   output logic [NUM_DOM-1:0] mask
);
   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      assign mask[d] = (code == DOM_ALL) || (code == dom_code_e'(d));
   end

   // R4: a decoded mask names one domain or all of them
   always_comb begin
      p_mask_shape_r4: assert (($countones(mask) == 1) || (mask == {NUM_DOM{1'b1}}))
         else $error("bad domain mask");
   end
endmodule

// File: rtl/pgate_access_seq.sv
module pgate_access_seq
   import pgate_proxy_pkg::*;
#(
   parameter int unsigned ACK_SYNC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [NUM_DOM-1:0] dom_mask,
   input  op_code_e           cmd_op,
   input  logic [NUM_DOM-1:0] wake_ack,
   input  logic               dn_ack,
   output logic [NUM_DOM-1:0] wake_req,
   output logic               dn_req,
   output logic               rd_cap,
   output logic               busy
);
   seq_state_e         state_q, state_d;
   logic [NUM_DOM-1:0] ack_s;

   if (ACK_SYNC == 0) begin : g_nosync
      assign ack_s = wake_ack;
   end else begin : g_sync
      logic [NUM_DOM-1:0] chain_q [ACK_SYNC];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < ACK_SYNC; i++) chain_q[i] <= '0;
         end else begin
            chain_q[0] <= wake_ack;
            for (int i = 1; i < ACK_SYNC; i++) chain_q[i] <= chain_q[i-1];
         end
      end
      assign ack_s = chain_q[ACK_SYNC-1];
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE: if (start) state_d = SQ_WAKE;
         SQ_WAKE: if ((ack_s & dom_mask) == dom_mask) state_d = SQ_XFER;
         SQ_XFER: if (dn_ack) state_d = SQ_REL;
         SQ_REL:  if ((ack_s & dom_mask) == '0) state_d = SQ_IDLE;
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_IDLE;
      else        state_q <= state_d;
   end

   assign busy     = (state_q != SQ_IDLE);
   assign dn_req   = (state_q == SQ_XFER);
   assign wake_req = ((state_q == SQ_WAKE) || (state_q == SQ_XFER)) ? dom_mask : '0;
   assign rd_cap   = (state_q == SQ_XFER) && dn_ack && (cmd_op == OP_RD);

   // R5: downstream access opens only after all selected domains acknowledged
   p_xfer_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dn_req) |-> $past((ack_s & dom_mask) == dom_mask))
      else $error("access started before wake");

   // R8: target completion releases the wake requests at the next edge
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req && dn_ack) |=> (wake_req == '0 && !dn_req))
      else $error("wake not released");

   // R8: busy clears only once synchronised acks are all low
   p_busy_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past((ack_s & dom_mask) == '0))
      else $error("busy cleared with ack high");
endmodule

// File: rtl/pgate_reg_proxy.sv
module pgate_reg_proxy
   import pgate_proxy_pkg::*;
#(
   parameter int unsigned HADDR_W  = 12,
   parameter int unsigned OFFS_W   = 24,
   parameter int unsigned DATA_OFF = 'hF00,
   parameter int unsigned CMD_OFF  = 'hF04,
   parameter int unsigned ACK_SYNC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hst_en,
   input  logic               hst_we,
   input  logic [HADDR_W-1:0] hst_addr,
   input  logic [31:0]        hst_wdata,
   output logic [31:0]        hst_rdata,
   output logic [NUM_DOM-1:0] wake_req,
   input  logic [NUM_DOM-1:0] wake_ack,
   output logic               dn_req,
   output logic               dn_we,
   output logic [OFFS_W-1:0]  dn_addr,
   output logic [31:0]        dn_wdata,
   input  logic [31:0]        dn_rdata,
   input  logic               dn_ack
);
   initial begin
      if (OFFS_W < 3 || OFFS_W > 24)
         $fatal(1, "OFFS_W must lie in 3..24");
      if (DATA_OFF == CMD_OFF || (DATA_OFF % 4) != 0 || (CMD_OFF % 4) != 0)
         $fatal(1, "window offsets must differ and be word aligned");
      if (DATA_OFF >= (1 << HADDR_W) || CMD_OFF >= (1 << HADDR_W))
         $fatal(1, "window offsets exceed host address width");
   end

   logic               start, busy, rd_cap;
   dom_code_e          cmd_dom;
   op_code_e           cmd_op;
   logic [OFFS_W-1:0]  cmd_offs;
   logic [31:0]        data_word;
   logic [NUM_DOM-1:0] dom_mask;

   pgate_win_regs #(
      .HADDR_W (HADDR_W),
      .OFFS_W  (OFFS_W),
      .DATA_OFF(DATA_OFF),
      .CMD_OFF (CMD_OFF)
   ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .hst_en   (hst_en),
      .hst_we   (hst_we),
      .hst_addr (hst_addr),
      .hst_wdata(hst_wdata),
      .hst_rdata(hst_rdata),
      .seq_busy (busy),
      .rd_cap   (rd_cap),
      .rd_word  (dn_rdata),
      .start    (start),
      .cmd_dom  (cmd_dom),
      .cmd_op   (cmd_op),
      .cmd_offs (cmd_offs),
      .data_word(data_word)
   );

   pgate_dom_decode u_dec (
      .code(cmd_dom),
      .mask(dom_mask)
   );

   pgate_access_seq #(
      .ACK_SYNC(ACK_SYNC)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .dom_mask(dom_mask),
      .cmd_op  (cmd_op),
      .wake_ack(wake_ack),
      .dn_ack  (dn_ack),
      .wake_req(wake_req),
      .dn_req  (dn_req),
      .rd_cap  (rd_cap),
      .busy    (busy)
   );

   assign dn_we    = (cmd_op == OP_WR);
   assign dn_addr  = cmd_offs;
   assign dn_wdata = data_word;

   // R1: nothing is requested while the block is idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (wake_req == '0 && !dn_req))
      else $error("request while idle");

   // R5, R6: downstream beat held steady until acknowledged
   p_beat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata)))
      else $error("downstream beat changed before ack");

   // R4: wake requests name one domain or all
   p_wake_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wake_req) || ($countones(wake_req) == NUM_DOM))
      else $error("bad wake pattern");
endmodule

// File: tb/sim_pgate_reg_proxy.sv
module sim_pgate_reg_proxy;
   localparam int SYNC = 2;
   localparam logic [11:0] A_DATA = 12'hF00;
   localparam logic [11:0] A_CMD  = 12'hF04;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_en = 1'b0, hst_we = 1'b0;
   logic [11:0] hst_addr = '0;
   logic [31:0] hst_wdata = '0;
   logic [31:0] hst_rdata;
   logic [2:0]  wake_req, wake_ack = '0;
   logic        dn_req, dn_we, dn_ack = 1'b0;
   logic [23:0] dn_addr;
   logic [31:0] dn_wdata, dn_rdata = '0;

   int checks = 0, failures = 0;
   always #4 clk = ~clk;

   pgate_reg_proxy u0 (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // power controller model: per-domain wake latency
   int pcnt [3];
   always @(negedge clk) begin
      for (int d = 0; d < 3; d++) begin
         if (wake_req[d]) begin
            pcnt[d]++;
            wake_ack[d] <= (pcnt[d] >= 3 + 2 * d);
         end else begin
            pcnt[d] = 0;
            wake_ack[d] <= 1'b0;
         end
      end
   end

   // target register file model
   function automatic logic [31:0] init_word(input int i);
      return 32'h5A00_0000 | (i * 32'h0001_0203);
   endfunction
   logic [31:0] mem [64];
   int wcnt = 0, beats = 0;
   initial for (int i = 0; i < 64; i++) mem[i] = init_word(i);
   always @(negedge clk) begin
      if (dn_ack) begin
         dn_ack <= 1'b0;
         wcnt = 0;
      end else if (dn_req) begin
         wcnt++;
         if (wcnt == 2) begin
            dn_ack   <= 1'b1;
            dn_rdata <= mem[dn_addr[7:2]];
            if (dn_we) mem[dn_addr[7:2]] = dn_wdata;
         end
      end
   end

   // behavioural reference model, advanced from bench-driven inputs only
   int          ms = 0;
   logic [31:0] mdata = '0;
   logic [1:0]  mdom = '0;
   logic        mop = 1'b0;
   logic [23:0] moff = '0;
   logic [2:0]  ackh [SYNC];
   logic [2:0]  maxwake = '0;
   initial for (int i = 0; i < SYNC; i++) ackh[i] = '0;

   function automatic logic [2:0] mask_of(input logic [1:0] c);
      return (c == 2'd3) ? 3'b111 : (3'b001 << c);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; mdata = '0; mdom = '0; mop = 1'b0; moff = '0;
         for (int i = 0; i < SYNC; i++) ackh[i] = '0;
      end else begin
         logic       idle0;
         logic [2:0] au, mm;
         idle0 = (ms == 0);
         au = ackh[SYNC-1];
         mm = mask_of(mdom);
         case (ms)
            0: if (hst_en && hst_we && hst_addr == A_CMD && hst_wdata[31]) begin
                  ms = 1; mdom = hst_wdata[29:28]; mop = hst_wdata[24]; moff = hst_wdata[23:0];
               end
            1: if ((au & mm) == mm) ms = 2;
            2: if (dn_ack) begin
                  if (mop) mdata = dn_rdata;
                  beats++;
                  ms = 3;
               end
            default: if ((au & mm) == 3'b000) ms = 0;
         endcase
         if (idle0 && hst_en && hst_we && hst_addr == A_DATA) mdata = hst_wdata;
         for (int i = SYNC - 1; i > 0; i--) ackh[i] = ackh[i-1];
         ackh[0] = wake_ack;
      end
   end

   // per-clock comparison, 2 ns after the edge
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         logic [31:0] exp_rd;
         logic [2:0]  exp_wk;
         if (hst_addr == A_DATA)     exp_rd = mdata;
         else if (hst_addr == A_CMD) exp_rd = {(ms != 0), 1'b0, mdom, 3'b000, mop, moff};
         else                        exp_rd = '0;
         exp_wk = (ms == 1 || ms == 2) ? mask_of(mdom) : 3'b000;
         maxwake |= wake_req;
         check("R2 host readback", hst_rdata, exp_rd);
         check("R4 wake_req", {29'd0, wake_req}, {29'd0, exp_wk});
         check("R5 dn_req", {31'd0, dn_req}, {31'd0, (ms == 2)});
         if (ms == 2) begin
            check("R6 dn_we", {31'd0, dn_we}, {31'd0, !mop});
            check("R6 dn_addr", {8'd0, dn_addr}, {8'd0, moff});
            if (!mop) check("R6 dn_wdata", dn_wdata, mdata);
         end
      end
   end

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected<100000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      hst_en = 1'b1; hst_we = 1'b1; hst_addr = a; hst_wdata = d;
      @(negedge clk);
      hst_en = 1'b0; hst_we = 1'b0; hst_wdata = '0;
   endtask

   task automatic hread(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      hst_addr = a;
      #1 d = hst_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 400; i++) begin
         hread(A_CMD, v);
         if (!v[31]) return;
      end
   endtask

   task automatic run_cmd(input logic [1:0] dom, input logic op, input logic [23:0] off,
                          input logic [2:0] exp_mask, input string tag);
      logic [31:0] v;
      maxwake = '0;
      hwrite(A_CMD, {1'b1, 1'b0, dom, 3'b000, op, off});
      hread(A_CMD, v);
      check({tag, " R3 busy set"}, {31'd0, v[31]}, 32'd1);
      wait_idle();
      check({tag, " R4 wake mask"}, {29'd0, maxwake}, {29'd0, exp_mask});
      check({tag, " R8 released"}, {29'd0, wake_req}, 32'd0);
   endtask

   initial begin
      logic [31:0] v, v2;
      int b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      hread(A_CMD, v);  check("R1 cmd after reset", v, 32'd0);
      hread(A_DATA, v); check("R1 data after reset", v, 32'd0);
      check("R1 no requests", {28'd0, wake_req, dn_req}, 32'd0);
      hread(12'h100, v); check("R2 unmapped offset", v, 32'd0);

      hwrite(A_DATA, 32'h1234_5678);
      hread(A_DATA, v); check("R2 data write", v, 32'h1234_5678);

      b0 = beats;
      hwrite(A_CMD, 32'h1100_0010);
      repeat (12) @(negedge clk);
      check("R3 no go bit no access", beats - b0, 0);

      // R6 write into render domain
      hwrite(A_DATA, 32'hCAFE_F00D);
      run_cmd(2'd1, 1'b0, 24'h20, 3'b010, "wr");
      check("R6 target written", mem[8], 32'hCAFE_F00D);

      // R7 reads in blitter and media domains
      run_cmd(2'd0, 1'b1, 24'h40, 3'b001, "rd0");
      hread(A_DATA, v); check("R7 read blitter", v, init_word(16));
      run_cmd(2'd2, 1'b1, 24'h44, 3'b100, "rd2");
      hread(A_DATA, v); check("R7 read media", v, init_word(17));

      // R10 64-bit value as two dword reads, all domains
      run_cmd(2'd3, 1'b1, 24'h08, 3'b111, "lo");
      hread(A_DATA, v);
      run_cmd(2'd3, 1'b1, 24'h0C, 3'b111, "hi");
      hread(A_DATA, v2);
      check("R10 low dword", v, init_word(2));
      check("R10 high dword", v2, init_word(3));

      // R9 writes during busy ignored
      b0 = beats;
      hwrite(A_CMD, {8'h91, 24'h10});
      hwrite(A_CMD, {8'h81, 24'h14});
      hwrite(A_DATA, 32'h0BAD_0BAD);
      wait_idle();
      check("R9 one beat only", beats - b0, 1);
      check("R9 target untouched", mem[5], init_word(5));
      hread(A_DATA, v); check("R9 data kept read", v, init_word(4));
      hread(A_CMD, v);  check("R9 command kept", v, {8'h11, 24'h10});

      // R2 reserved bits read zero
      hwrite(A_CMD, 32'hCE00_0030);
      wait_idle();
      hread(A_CMD, v); check("R2 reserved bits", v, 32'h0000_0030);

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule